// File: doc/BRIEF.md
# HDLC Receive Address Recognizer

This block decides whether an incoming HDLC frame is meant for the local station. It does this by looking at the frame's leading address bytes. An upstream deframer delivers the frame as a byte stream. Each byte arrives with a valid strobe and may also carry a start-of-frame or end-of-frame qualifier. For every frame the block produces one decision pulse. The pulse carries an accept or reject verdict and a code telling which compare value produced the match.

A 3-bit mode input chooses how the address is checked:
- compare one address byte;
- compare two address bytes;
- compare only the first (high) byte;
- compare only the second (low) byte;
- compare nothing.

Two compare values apply to the high byte and two to the low byte. Beyond those, the high byte also matches a fixed group pair, and the low byte also matches a fixed broadcast value when two-byte addressing or low-only checking is used. The mode is captured on the first byte of a frame and holds for that whole frame. A new start-of-frame always restarts the recognizer, even if the previous frame never ended.

Top module: `hdlc_addr_filter`

## Requirements
- R1: Mode codes 000 and 001 are reserved. A frame that starts under either of them gets a reject decision one cycle after its first byte.
- R2: In mode 010 only the first byte is the address. It is accepted if it equals `lo_cmp_a` or `lo_cmp_b`. The broadcast value does not match in this mode, and the decision follows the first byte.
- R3: In mode 011 the first byte must equal `hi_cmp_a`, `hi_cmp_b`, FC hex or FE hex. The second byte must also equal `lo_cmp_a`, `lo_cmp_b` or FF hex. The decision follows the second byte.
- R4: Mode 110 (the reset value of the captured mode) accepts every frame one cycle after its first byte, with source code 3.
- R5: Mode 100 accepts every frame one cycle after its first byte, with source code 3.
- R6: Mode 111 checks only the first byte, against `hi_cmp_a`, `hi_cmp_b`, FC hex or FE hex.
- R7: Mode 101 ignores the first byte. It checks only the second byte, against `lo_cmp_a`, `lo_cmp_b` or FF hex.
- R8: If a frame ends (end-of-frame on a byte) before the byte a two-byte mode needs, the frame is rejected one cycle after that byte.
- R9: A byte carrying start-of-frame discards any partial frame and starts a new one.
- R10: The mode is sampled on the start-of-frame byte. Changing `mode` later in the frame has no effect on that frame's decision.
- R11: `dec_src` is 0 for a compare-value-a match, 1 for compare-value-b, 2 for the group or broadcast value, and 3 for a reject or for no compare. Priority is a over b over fixed. With two bytes compared, the low-byte source is reported.
- R12: Exactly one decision is made per frame. Bytes after the decision, and bytes before any start-of-frame, produce no `dec_vld`.
- R13: After reset, `dec_vld`, `dec_accept` are 0 and `dec_src` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Address check mode, sampled on start-of-frame |
| hi_cmp_a | input | BW | First compare value for the high address byte |
| hi_cmp_b | input | BW | Second compare value for the high address byte |
| lo_cmp_a | input | BW | First compare value for the low address byte |
| lo_cmp_b | input | BW | Second compare value for the low address byte |
| byte_vld | input | 1 | Byte strobe; the other stream inputs count only when it is high |
| byte_data | input | BW | Received byte |
| sof | input | 1 | This byte is the first of a frame |
| eof | input | 1 | This byte is the last of a frame |
| dec_vld | output | 1 | One-cycle pulse: a decision is present |
| dec_accept | output | 1 | Frame accepted |
| dec_src | output | 2 | Which compare value matched |

## Verification
The bench uses the default parameters. These are an 8-bit byte, group values FC and FE, and broadcast FF. With these values every encoding in the requirements can be driven literally.

The bench also changes the compare-value inputs at run time. It makes compare values collide with each other and with the fixed values, so that the a-over-b-over-fixed priority is exercised. A behavioural model collects each frame's bytes in a queue and evaluates the address once the needed bytes have arrived. This covers:
- truncated frames;
- restarts in the middle of a frame;
- bytes outside any frame;
- mode changes in the middle of a frame.

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter #(
  parameter int BW = 8,
  parameter logic [BW-1:0] GRP_A = 8'hFC,
  parameter logic [BW-1:0] GRP_B = 8'hFE,
  parameter logic [BW-1:0] BCAST = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [BW-1:0] hi_cmp_a,
  input  logic [BW-1:0] hi_cmp_b,
  input  logic [BW-1:0] lo_cmp_a,
  input  logic [BW-1:0] lo_cmp_b,
  input  logic          byte_vld,
  input  logic [BW-1:0] byte_data,
  input  logic          sof,
  input  logic          eof,
  output logic          dec_vld,
  output logic          dec_accept,
  output logic [1:0]    dec_src
);
  localparam logic [2:0] M_ONE = 3'b010;
  localparam logic [2:0] M_TWO = 3'b011;
  localparam logic [2:0] M_XT  = 3'b100;
  localparam logic [2:0] M_LO  = 3'b101;
  localparam logic [2:0] M_ALL = 3'b110;
  localparam logic [2:0] M_HI  = 3'b111;
  localparam logic [1:0] S_A    = 2'd0;
  localparam logic [1:0] S_B    = 2'd1;
  localparam logic [1:0] S_FIX  = 2'd2;
  localparam logic [1:0] S_NONE = 2'd3;

  logic       wait2, hi_ok;
  logic [2:0] fmode;
  logic       decide, acc, go2;
  logic [1:0] src;

  wire first  = byte_vld & sof;
  wire second = byte_vld & ~sof & wait2;

  wire [1:0] lo_own = (byte_data == lo_cmp_a) ? S_A :
                      (byte_data == lo_cmp_b) ? S_B : S_NONE;
  wire [1:0] lo_hit = (lo_own != S_NONE) ? lo_own :
                      (byte_data == BCAST) ? S_FIX : S_NONE;
  wire [1:0] hi_hit = (byte_data == hi_cmp_a) ? S_A :
                      (byte_data == hi_cmp_b) ? S_B :
                      (byte_data == GRP_A || byte_data == GRP_B) ? S_FIX : S_NONE;

  always_comb begin
    decide = 1'b0;
    acc    = 1'b0;
    src    = S_NONE;
    go2    = 1'b0;
    if (first) begin
      unique case (mode)
        M_ONE: begin
          decide = 1'b1;
          acc    = (lo_own != S_NONE);
          src    = lo_own;
        end
        M_TWO, M_LO: begin
          if (eof) decide = 1'b1;
          else     go2    = 1'b1;
        end
        M_HI: begin
          decide = 1'b1;
          acc    = (hi_hit != S_NONE);
          src    = hi_hit;
        end
        M_ALL, M_XT: begin
          decide = 1'b1;
          acc    = 1'b1;
        end
        default: decide = 1'b1;
      endcase
    end else if (second) begin
      decide = 1'b1;
      acc    = (lo_hit != S_NONE) && ((fmode == M_LO) || hi_ok);
      src    = acc ? lo_hit : S_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait2      <= 1'b0;
      hi_ok      <= 1'b0;
      fmode      <= M_ALL;
      dec_vld    <= 1'b0;
      dec_accept <= 1'b0;
      dec_src    <= S_NONE;
    end else begin
      wait2      <= go2 | (wait2 & ~byte_vld);
      if (first) begin
        fmode <= mode;
        hi_ok <= (hi_hit != S_NONE);
      end
      dec_vld    <= decide;
      dec_accept <= acc;
      dec_src    <= decide ? src : S_NONE;
    end
  end
endmodule

// File: rtl/hdlc_addr_filter_chk.sv
module hdlc_addr_filter_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode,
  input logic [BW-1:0] lo_cmp_a,
  input logic          byte_vld,
  input logic [BW-1:0] byte_data,
  input logic          sof,
  input logic          dec_vld,
  input logic          dec_accept,
  input logic [1:0]    dec_src
);
  // R12
  dec_follows_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(byte_vld));
  // R11
  reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !dec_accept) |-> dec_src == 2'd3);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_vld |-> (!dec_accept && dec_src == 2'd3));
  // R1
  reserved_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && sof && mode[2:1] == 2'b00) |=> (dec_vld && !dec_accept));
  // R4
  accept_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && sof && mode == 3'b110) |=> (dec_vld && dec_accept && dec_src == 2'd3));
  // R2
  one_byte_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && sof && mode == 3'b010 && byte_data == lo_cmp_a)
      |=> (dec_vld && dec_accept && dec_src == 2'd0));
endmodule

bind hdlc_addr_filter hdlc_addr_filter_chk #(.BW(BW)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .lo_cmp_a(lo_cmp_a),
  .byte_vld(byte_vld), .byte_data(byte_data), .sof(sof),
  .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_src(dec_src));

// File: tb/hdlc_addr_filter_tb_top.sv
module hdlc_addr_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'b110;
  logic [7:0] hi_a = 8'h30, hi_b = 8'h44, lo_a = 8'h11, lo_b = 8'h22;
  logic byte_vld = 1'b0, sof = 1'b0, eof = 1'b0;
  logic [7:0] bdat = 8'h00;
  logic dec_vld, dec_accept;
  logic [1:0] dec_src;

  always #4 clk = ~clk;

  hdlc_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .hi_cmp_a(hi_a), .hi_cmp_b(hi_b), .lo_cmp_a(lo_a), .lo_cmp_b(lo_b),
    .byte_vld(byte_vld), .byte_data(bdat), .sof(sof), .eof(eof),
    .dec_vld(dec_vld), .dec_accept(dec_accept), .dec_src(dec_src));

  int compared = 0, mismatched = 0;
  string cur_req = "R13";
  bit done = 0;

  int e_vld = 0, e_acc = 0, e_src = 3;
  int q[$];
  int fm = 6;
  bit active = 0;

  function automatic int lo_m(int b, bit bc);
    if (b == lo_a) return 0;
    if (b == lo_b) return 1;
    if (bc && b == 8'hFF) return 2;
    return 3;
  endfunction
  function automatic int hi_m(int b);
    if (b == hi_a) return 0;
    if (b == hi_b) return 1;
    if (b == 8'hFC || b == 8'hFE) return 2;
    return 3;
  endfunction
  function automatic int need(int m);
    return (m == 3 || m == 5) ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    e_vld = 0; e_acc = 0; e_src = 3;
    if (!rst_n) begin
      active = 0; q.delete();
    end else if (byte_vld) begin
      if (sof) begin
        q.delete(); q.push_back(bdat); fm = mode; active = 1;
      end else if (active) q.push_back(bdat);
      if (active && (q.size() >= need(fm) || eof)) begin
        int s;
        active = 0; e_vld = 1; s = 3;
        if (q.size() >= need(fm)) begin
          case (fm)
            2: s = lo_m(q[0], 0);
            3: s = (hi_m(q[0]) != 3) ? lo_m(q[1], 1) : 3;
            7: s = hi_m(q[0]);
            5: s = lo_m(q[1], 1);
            6, 4: begin e_acc = 1; s = 3; end
            default: s = 3;
          endcase
          if (fm != 6 && fm != 4) e_acc = (s != 3);
        end
        e_src = s;
      end
    end
  end

  always @(negedge clk) if (!done) begin
    compared++;
    if (dec_vld !== e_vld[0] || dec_accept !== e_acc[0] || dec_src !== e_src[1:0]) begin
      mismatched++;
      $display("FAIL %s: vld/acc/src actual %0b/%0b/%0d expected %0d/%0d/%0d",
               cur_req, dec_vld, dec_accept, dec_src, e_vld, e_acc, e_src);
    end
  end

  task automatic put(input bit s, input bit e, input logic [7:0] d);
    @(negedge clk);
    byte_vld = 1; sof = s; eof = e; bdat = d;
    @(negedge clk);
    byte_vld = 0; sof = 0; eof = 0;
  endtask

  task automatic frame(input string r, input logic [2:0] m, input int b0, input int b1, input int n);
    cur_req = r;
    @(negedge clk); mode = m;
    put(1, n == 1, b0[7:0]);
    if (n > 1) put(0, 1, b1[7:0]);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    frame("R1", 3'b000, 8'h11, 0, 1);
    frame("R1", 3'b001, 8'hFC, 8'h11, 2);
    frame("R2", 3'b010, 8'h11, 0, 1);
    frame("R2", 3'b010, 8'h22, 0, 1);
    frame("R2", 3'b010, 8'hFF, 0, 1);
    frame("R2", 3'b010, 8'h55, 8'h11, 2);
    frame("R3", 3'b011, 8'h30, 8'h22, 2);
    frame("R3", 3'b011, 8'hFC, 8'hFF, 2);
    frame("R3", 3'b011, 8'hFE, 8'h11, 2);
    frame("R3", 3'b011, 8'hFD, 8'h11, 2);
    frame("R3", 3'b011, 8'h44, 8'h33, 2);
    frame("R4", 3'b110, 8'h99, 0, 1);
    frame("R5", 3'b100, 8'h00, 8'h01, 2);
    frame("R6", 3'b111, 8'h44, 8'h99, 2);
    frame("R6", 3'b111, 8'hFE, 0, 1);
    frame("R6", 3'b111, 8'h11, 0, 1);
    frame("R7", 3'b101, 8'h99, 8'h22, 2);
    frame("R7", 3'b101, 8'h30, 8'h77, 2);
    frame("R7", 3'b101, 8'h00, 8'hFF, 2);
    frame("R8", 3'b011, 8'h30, 0, 1);
    frame("R8", 3'b101, 8'h00, 0, 1);
    // R9: restart mid-frame
    cur_req = "R9";
    @(negedge clk); mode = 3'b011;
    put(1, 0, 8'h30);
    put(1, 0, 8'h99);
    put(0, 1, 8'h11);
    repeat (2) @(negedge clk);
    // R10: mode changes after start-of-frame
    cur_req = "R10";
    @(negedge clk); mode = 3'b011;
    put(1, 0, 8'h30);
    mode = 3'b000;
    put(0, 1, 8'h22);
    repeat (2) @(negedge clk);
    // R11: priority between colliding compare values
    lo_b = 8'h11;
    frame("R11", 3'b010, 8'h11, 0, 1);
    lo_a = 8'hFF;
    frame("R11", 3'b101, 8'h00, 8'hFF, 2);
    hi_a = 8'hFC;
    frame("R11", 3'b111, 8'hFC, 0, 1);
    lo_a = 8'h11; lo_b = 8'h22; hi_a = 8'h30;
    // R12: trailing bytes and bytes outside any frame
    cur_req = "R12";
    @(negedge clk); mode = 3'b010;
    put(1, 0, 8'h11);
    put(0, 0, 8'h22);
    put(0, 1, 8'h11);
    put(0, 0, 8'h11);
    repeat (3) @(negedge clk);
    // R13: reset mid-frame returns outputs to idle
    cur_req = "R13";
    mode = 3'b011;
    put(1, 0, 8'h30);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    put(0, 1, 8'h11);
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL %s: watchdog actual timeout expected completion", cur_req);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule